// File: doc/BRIEF.md
# Packet Payload Whitening Scrambler

This block whitens packet data before it goes on air and removes the whitening on the receive side. A 9-bit linear feedback shift register (polynomial x^9 + x^5 + 1) produces a pseudo-random bit sequence. That sequence is XORed onto every bit inside the whitening window, which is the payload followed by its 16-bit CRC. Applying the same sequence a second time restores the original data. For that reason one instance serves as the transmit scrambler and another instance, built the same way, serves as the receive descrambler.

The framing logic upstream drives three strobes: a valid strobe for each beat, a start-of-packet strobe on the first beat of a packet, and a window flag that is high on payload and CRC beats. Preamble, sync and header beats have the window flag low. They pass through untouched and do not move the sequence. A single configuration enable turns the whitening on. When the enable is low, the stream passes straight through. The data width is a parameter: 1 selects serial operation, and 8 (the default) selects byte-wide operation.

Top module: `whitening_scrambler`

## Requirements
- R1: Every output lags its input by exactly one clock. outValid and outSop follow inValid and inSop one cycle later. While reset is asserted, all outputs are zero.
- R2: When cfgWhitenEn is 0, every valid beat reaches outData unchanged, one cycle later.
- R3: A valid beat with inWindow = 0 (preamble, sync or header) is output unchanged.
- R4: A valid beat with inWindow = 1 and cfgWhitenEn = 1 is output as inData XOR the next DATA_W sequence bits. The generator state s[8:0] emits s[0] and then becomes {s[0]^s[5], s[8:1]}.
- R5: A valid beat with inSop = 1 reloads the generator with 0x1FF. If that same beat has the window flag set, it uses the reloaded state, so its key byte is 0xFF.
- R6: Cycles with inValid = 0 do not advance the generator. A packet sent with stall cycles produces the same whitened data as the same packet sent without them.
- R7: Valid beats with inWindow = 0 do not advance the generator, even when they fall between window beats.
- R8: In byte-wide mode the first generated bit is XORed onto bit 7, which goes on air first. The second byte after a reload therefore uses key 0x87.
- R9: Sending a packet's output back through the block with the same framing restores the original bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWhitenEn | input | 1 | Whitening enable from the configuration register |
| inValid | input | 1 | Input beat valid |
| inSop | input | 1 | First beat of a packet |
| inWindow | input | 1 | Beat belongs to the payload or the CRC |
| inData | input | DATA_W | Input data; in byte mode bit 7 goes on air first |
| outValid | output | 1 | Output beat valid |
| outSop | output | 1 | Output first beat of a packet |
| outData | output | DATA_W | Whitened or passed-through data |

## Verification
The assertions assume that the framing strobes are sane. inSop and inWindow have meaning only when inValid is high. Each packet starts with exactly one start-of-packet beat before any of its window beats. cfgWhitenEn stays constant for the length of a packet. The stimulus builds every packet from the same template: a start beat, header beats and window beats. The enable changes only between packets. Stall cycles, with valid low and the other strobes cleared, are inserted at random positions.

// File: rtl/whiten_pkg.sv
package whiten_pkg;
  localparam int LFSR_W = 9;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 9'h1FF;

  // Per-beat strobes passed from control to datapath
  typedef struct packed {
    logic load;  // reload generator with seed
    logic step;  // advance generator by one beat
    logic mask;  // apply keystream to this beat
    logic pass;  // beat is valid
    logic sop;   // beat starts a packet
  } whCtl_t;

  // x^9 + x^5 + 1, output taken from bit 0
  function automatic logic [LFSR_W-1:0] lfsrNext(input logic [LFSR_W-1:0] s);
    return {s[0] ^ s[5], s[LFSR_W-1:1]};
  endfunction
endpackage

// File: rtl/whiten_ctrl.sv
module whiten_ctrl
  import whiten_pkg::*;
(
  input  logic   cfgWhitenEn,
  input  logic   inValid,
  input  logic   inSop,
  input  logic   inWindow,
  output whCtl_t ctl
);
  logic winBeat;

  always_comb begin
    winBeat  = inValid && inWindow;
    ctl.pass = inValid;
    ctl.sop  = inValid && inSop;
    ctl.load = inValid && inSop;
    ctl.step = winBeat && cfgWhitenEn;
    ctl.mask = winBeat && cfgWhitenEn;
  end
endmodule

// File: rtl/whiten_dp.sv
module whiten_dp
  import whiten_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  whCtl_t            ctl,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic              outSop,
  output logic [DATA_W-1:0] outData
);
  localparam int STEPS = DATA_W;

  logic [LFSR_W-1:0] lfsrQ;
  logic [LFSR_W-1:0] baseState;
  logic [LFSR_W-1:0] chain [0:STEPS];
  logic [DATA_W-1:0] keyBits;

  assign baseState = ctl.load ? LFSR_SEED : lfsrQ;
  assign chain[0]  = baseState;

  // One generator stage per data bit; the first bit generated lands on the MSB
  for (genvar i = 0; i < STEPS; i++) begin : g_stage
    assign keyBits[DATA_W-1-i] = chain[i][0];
    assign chain[i+1]          = lfsrNext(chain[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsrQ    <= LFSR_SEED;
      outValid <= 1'b0;
      outSop   <= 1'b0;
      outData  <= '0;
    end else begin
      if (ctl.step)      lfsrQ <= chain[STEPS];
      else if (ctl.load) lfsrQ <= LFSR_SEED;
      outValid <= ctl.pass;
      outSop   <= ctl.sop;
      outData  <= ctl.mask ? (inData ^ keyBits) : inData;
    end
  end

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid == $past(ctl.pass)) && (outSop == $past(ctl.sop)));

  // R3
  bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.pass && !ctl.mask) |-> outData == $past(inData));

  // R4
  nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);

  // R5
  seed_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.load && !ctl.step) |-> lfsrQ == LFSR_SEED);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.load || ctl.step) |-> $stable(lfsrQ));
endmodule

// File: rtl/whitening_scrambler.sv
module whitening_scrambler
  import whiten_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWhitenEn,
  input  logic              inValid,
  input  logic              inSop,
  input  logic              inWindow,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic              outSop,
  output logic [DATA_W-1:0] outData
);
  whCtl_t ctl;

  whiten_ctrl u_ctrl (
    .cfgWhitenEn(cfgWhitenEn),
    .inValid    (inValid),
    .inSop      (inSop),
    .inWindow   (inWindow),
    .ctl        (ctl)
  );

  whiten_dp #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .inData  (inData),
    .outValid(outValid),
    .outSop  (outSop),
    .outData (outData)
  );
endmodule

// File: tb/sim_whitening_scrambler.sv
module sim_whitening_scrambler;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWhitenEn = 1'b0;
  logic inValid = 1'b0;
  logic inSop = 1'b0;
  logic inWindow = 1'b0;
  logic [W-1:0] inData = '0;
  logic outValid, outSop;
  logic [W-1:0] outData;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [8:0] mState = 9'h1FF;
  logic [W-1:0] lastOut;
  logic [W-1:0] origBuf [0:63];
  logic [W-1:0] captBuf [0:63];

  always #4 clk = ~clk;

  whitening_scrambler #(.DATA_W(W)) u0 (
    .clk(clk), .rstN(rstN), .cfgWhitenEn(cfgWhitenEn), .inValid(inValid),
    .inSop(inSop), .inWindow(inWindow), .inData(inData),
    .outValid(outValid), .outSop(outSop), .outData(outData)
  );

  function automatic logic [8:0] modelStep(input logic [8:0] s);
    logic fb;
    fb = s[5] ^ s[0];
    return {fb, s[8:1]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one beat at a negedge, then check it at the next negedge
  task automatic beat(input bit v, input bit s, input bit w, input logic [W-1:0] d,
                      input string tag);
    logic [W-1:0] exp;
    if (v && s) mState = 9'h1FF;
    exp = d;
    if (v && w && cfgWhitenEn)
      for (int k = 0; k < W; k++) begin
        exp[W-1-k] = exp[W-1-k] ^ mState[0];
        mState = modelStep(mState);
      end
    inValid = v; inSop = s; inWindow = w; inData = d;
    @(negedge clk);
    chk(outValid == v, {tag, " valid"}, outValid, v);
    chk(outSop == (v && s), {tag, " sop"}, outSop, v && s);
    if (v) chk(outData == exp, {tag, " data"}, outData, exp);
    lastOut = outData;
    inValid = 0; inSop = 0; inWindow = 0;
  endtask

  task automatic maybeStall(input bit en);
    if (en && ($urandom % 3 == 0)) beat(0, 0, 0, W'($urandom), "R6 stall");
  endtask

  // Header beats, then payload plus two CRC beats in the window
  task automatic sendPacket(input int nPay, input bit en, input bit stalls,
                            input bit useBuf, input bit capture);
    string tg;
    logic [W-1:0] d;
    cfgWhitenEn = en;
    tg = en ? "R4" : "R2";
    beat(1, 1, 0, W'($urandom), "R3 sop");
    maybeStall(stalls);
    beat(1, 0, 0, W'($urandom), "R3 hdr");
    beat(1, 0, 0, W'($urandom), "R3 hdr");
    for (int i = 0; i < nPay + 2; i++) begin
      maybeStall(stalls);
      d = useBuf ? captBuf[i] : W'($urandom);
      if (!useBuf) origBuf[i] = d;
      beat(1, 0, 1, d, tg);
      if (capture) captBuf[i] = lastOut;
      if (useBuf) chk(lastOut == origBuf[i], "R9 restore", lastOut, origBuf[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(outValid == 0 && outSop == 0, "R1 reset strobes", {outValid, outSop}, 0);
    chk(outData == 0, "R1 reset data", outData, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R5 and R8 directed: reload and window on the same beat, zeros in
    cfgWhitenEn = 1;
    beat(1, 1, 1, 8'h00, "R5 seed");
    chk(lastOut == 8'hFF, "R5 first key", lastOut, 8'hFF);
    beat(1, 0, 1, 8'h00, "R8 order");
    chk(lastOut == 8'h87, "R8 second key", lastOut, 8'h87);

    // R7: a non-window beat inside the window neither changes nor advances
    beat(1, 1, 0, 8'h11, "R7 sop");
    beat(1, 0, 1, 8'h00, "R7 pay");
    beat(1, 0, 0, 8'hA5, "R7 gap");
    chk(lastOut == 8'hA5, "R7 gap raw", lastOut, 8'hA5);
    beat(1, 0, 1, 8'h00, "R7 pay");
    chk(lastOut == 8'h87, "R7 continuity", lastOut, 8'h87);

    // R6: the same packet with and without stalls gives the same data
    beat(1, 1, 1, 8'h3C, "R6 nostall");
    beat(1, 0, 1, 8'hC3, "R6 nostall");
    captBuf[0] = lastOut;
    beat(1, 1, 1, 8'h3C, "R6 stalled");
    beat(0, 0, 0, 8'h77, "R6 stall");
    beat(0, 0, 1, 8'h77, "R6 stall");
    beat(1, 0, 1, 8'hC3, "R6 stalled");
    chk(lastOut == captBuf[0], "R6 equal", lastOut, captBuf[0]);

    // R2: disabled passes everything
    sendPacket(6, 0, 1, 0, 0);

    // R9: scramble, then feed the result back through
    sendPacket(10, 1, 1, 0, 1);
    sendPacket(10, 1, 0, 1, 0);

    // Random mix
    for (int p = 0; p < 40; p++)
      sendPacket(1 + ($urandom % 20), ($urandom % 4) != 0, 1, 0, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule